// File: doc/BRIEF.md
# Segment Address Translator

The block turns a two-part logical address, made of a segment number and an offset within that segment, into a physical address. It keeps a small table of segment descriptors. Each descriptor holds the segment's start address in physical memory, the segment's length, a valid flag and three access-right flags for read, write and execute. A write port loads the descriptors. A plain input gives the number of segments the current program may use.

A translation request carries a segment number, an offset and an access kind. The request passes through four checks in a fixed order: the segment number against the segment count, then the descriptor's valid flag, then the offset against the length, then the access kind against the rights. One response comes back for each request, in the cycle after the request is accepted. A response that passes every check gives the start address plus the offset. A response that fails gives the code of the highest-priority check that failed, and its address is zero.

Requests and responses are valid/ready streams. The block holds one response. A new request is accepted only while that slot is empty or is being emptied in the same cycle. While the response is stalled, the response stays frozen and no request is accepted.

Top module: `seg_xlate`

## Requirements
- R1: After reset `rsp_valid` is 0, and every descriptor is invalid with zero start, zero length and no rights.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` equals `!rsp_valid || rsp_ready`. The response to an accepted request is presented with `rsp_valid` = 1 from the next cycle on.
- R3: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_addr` and `rsp_fault` stay unchanged and no request is accepted.
- R4: If the segment number is greater than or equal to `seg_count`, the fault code is 1 (out of range). This check wins over every other check.
- R5: If the segment is in range and its descriptor's valid flag is 0, the fault code is 2 (invalid segment). This check wins over the length and rights checks.
- R6: If the offset is greater than or equal to the descriptor length, the fault code is 3 (length violation). This check wins over the rights check. An offset of length minus one passes.
- R7: Access kind 0 needs right bit 0 (read), kind 1 needs bit 1 (write) and kind 2 needs bit 2 (execute). A missing right gives fault code 4. Kind 3 always gives fault code 4.
- R8: A request that passes every check returns fault code 0 and address = start + offset, taken modulo 2^PA_W.
- R9: Every response with a nonzero fault code carries `rsp_addr` = 0.
- R10: When `tbl_we` is 1, the descriptor at `tbl_idx` is replaced at the clock edge. A request accepted in that same cycle is checked against the old descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_count | input | SEG_W+1 | Number of usable segments |
| tbl_we | input | 1 | Descriptor write strobe |
| tbl_idx | input | SEG_W | Descriptor index to write |
| tbl_base | input | PA_W | Segment start address |
| tbl_limit | input | OFF_W+1 | Segment length |
| tbl_valid | input | 1 | Descriptor valid flag |
| tbl_perm | input | 3 | Rights: bit0 read, bit1 write, bit2 execute |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | PA_W | Physical address, zero on a fault |
| rsp_fault | output | 3 | 0 none, 1 range, 2 invalid, 3 length, 4 rights |

## Verification
The assertions assume that reset is held for at least one edge before any request arrives. They also assume that `seg_count` and the request fields hold steady around each accepting edge, because the range check reads them at that edge. The stimulus drives every input only on falling edges and keeps `seg_count` within 0 to 2^SEG_W. Descriptor writes never coincide with a stalled response, except in the one test that writes a descriptor in the same cycle as a request aimed at it.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_RANGE   = 3'd1,
    FLT_INVALID = 3'd2,
    FLT_LIMIT   = 3'd3,
    FLT_PERM    = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_W = 3;
  localparam int PERM_R = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_X = 2;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [SEG_W-1:0]                 wr_idx,
  input  logic [PA_W-1:0]                  wr_base,
  input  logic [OFF_W:0]                   wr_limit,
  input  logic                             wr_valid,
  input  logic [seg_xlate_pkg::PERM_W-1:0] wr_perm,
  input  logic [SEG_W-1:0]                 rd_idx,
  output logic [PA_W-1:0]                  rd_base,
  output logic [OFF_W:0]                   rd_limit,
  output logic                             rd_valid,
  output logic [seg_xlate_pkg::PERM_W-1:0] rd_perm
);
  localparam int ENTRIES = 1 << SEG_W;

  logic [PA_W-1:0]                  base_q  [ENTRIES];
  logic [OFF_W:0]                   limit_q [ENTRIES];
  logic                             valid_q [ENTRIES];
  logic [seg_xlate_pkg::PERM_W-1:0] perm_q  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == SEG_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[e]  <= '0;
        limit_q[e] <= '0;
        valid_q[e] <= 1'b0;
        perm_q[e]  <= '0;
      end else if (hit) begin
        base_q[e]  <= wr_base;
        limit_q[e] <= wr_limit;
        valid_q[e] <= wr_valid;
        perm_q[e]  <= wr_perm;
      end
    end
  end

  assign rd_base  = base_q[rd_idx];
  assign rd_limit = limit_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
  assign rd_perm  = perm_q[rd_idx];
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  input  acc_e              acc,
  input  logic [SEG_W:0]    count,
  input  logic [PA_W-1:0]   ent_base,
  input  logic [OFF_W:0]    ent_limit,
  input  logic              ent_valid,
  input  logic [PERM_W-1:0] ent_perm,
  output fault_e            fault,
  output logic [PA_W-1:0]   addr
);
  logic out_of_range;
  logic over_limit;
  logic rights_ok;

  assign out_of_range = {1'b0, seg} >= count;
  assign over_limit   = {1'b0, off} >= ent_limit;

  always_comb begin
    unique case (acc)
      ACC_READ:  rights_ok = ent_perm[PERM_R];
      ACC_WRITE: rights_ok = ent_perm[PERM_WR];
      ACC_EXEC:  rights_ok = ent_perm[PERM_X];
      default:   rights_ok = 1'b0;
    endcase
  end

  always_comb begin
    fault = FLT_NONE;
    addr  = '0;
    if (out_of_range)    fault = FLT_RANGE;
    else if (!ent_valid) fault = FLT_INVALID;
    else if (over_limit) fault = FLT_LIMIT;
    else if (!rights_ok) fault = FLT_PERM;
    else                 addr  = ent_base + PA_W'(off);
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEG_W:0]    seg_count,
  input  logic              tbl_we,
  input  logic [SEG_W-1:0]  tbl_idx,
  input  logic [PA_W-1:0]   tbl_base,
  input  logic [OFF_W:0]    tbl_limit,
  input  logic              tbl_valid,
  input  logic [2:0]        tbl_perm,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_addr,
  output logic [2:0]        rsp_fault
);
  logic [PA_W-1:0]   ent_base;
  logic [OFF_W:0]    ent_limit;
  logic              ent_valid;
  logic [PERM_W-1:0] ent_perm;
  fault_e            chk_fault;
  logic [PA_W-1:0]   chk_addr;
  logic              accept;
  fault_e            fault_q;

  seg_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_we),
    .wr_idx   (tbl_idx),
    .wr_base  (tbl_base),
    .wr_limit (tbl_limit),
    .wr_valid (tbl_valid),
    .wr_perm  (tbl_perm),
    .rd_idx   (req_seg),
    .rd_base  (ent_base),
    .rd_limit (ent_limit),
    .rd_valid (ent_valid),
    .rd_perm  (ent_perm)
  );

  seg_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_check (
    .seg       (req_seg),
    .off       (req_off),
    .acc       (acc_e'(req_acc)),
    .count     (seg_count),
    .ent_base  (ent_base),
    .ent_limit (ent_limit),
    .ent_valid (ent_valid),
    .ent_perm  (ent_perm),
    .fault     (chk_fault),
    .addr      (chk_addr)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      fault_q   <= FLT_NONE;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_addr  <= chk_addr;
      fault_q   <= chk_fault;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_fault = fault_q;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_W = 3,
  parameter int PA_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEG_W:0]   seg_count,
  input logic             req_valid,
  input logic             req_ready,
  input logic [SEG_W-1:0] req_seg,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_addr,
  input logic [2:0]       rsp_fault
);
  AST_ACCEPT_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R2

  AST_EMPTY_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready); // R2

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_fault)); // R3

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R3

  AST_RANGE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && ({1'b0, req_seg} >= seg_count) |=> rsp_fault == 3'd1); // R4

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault != 3'd0) |-> rsp_addr == '0); // R9

  AST_FAULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault <= 3'd4); // R4
endmodule

bind seg_xlate seg_xlate_chk #(.SEG_W(SEG_W), .PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .seg_count (seg_count),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_seg   (req_seg),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_addr  (rsp_addr),
  .rsp_fault (rsp_fault)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  localparam int SEG_W = 3;
  localparam int OFF_W = 12;
  localparam int PA_W  = 16;
  localparam int NVEC  = 15;

  // seg[39:37] off[36:25] acc[24:23] count[22:19] fault[18:16] addr[15:0]
  localparam logic [39:0] VEC [NVEC] = '{
    {3'd0, 12'h010, 2'd0, 4'd4, 3'd0, 16'h1010},  // R8 read ok
    {3'd0, 12'h0FF, 2'd2, 4'd4, 3'd0, 16'h10FF},  // R6 R8 last byte passes
    {3'd0, 12'h100, 2'd0, 4'd4, 3'd3, 16'h0000},  // R6 offset == length
    {3'd0, 12'h010, 2'd1, 4'd4, 3'd4, 16'h0000},  // R7 no write right
    {3'd0, 12'h100, 2'd1, 4'd4, 3'd3, 16'h0000},  // R6 over R7
    {3'd1, 12'h03F, 2'd1, 4'd4, 3'd0, 16'h203F},  // R8 write ok
    {3'd1, 12'h000, 2'd2, 4'd4, 3'd4, 16'h0000},  // R7 no execute right
    {3'd2, 12'h000, 2'd0, 4'd4, 3'd2, 16'h0000},  // R5 invalid
    {3'd2, 12'h300, 2'd1, 4'd4, 3'd2, 16'h0000},  // R5 over R6
    {3'd4, 12'h000, 2'd0, 4'd4, 3'd1, 16'h0000},  // R4 seg == count
    {3'd4, 12'h000, 2'd0, 4'd5, 3'd4, 16'h0000},  // R7 no rights at all
    {3'd3, 12'h020, 2'd0, 4'd4, 3'd0, 16'h0010},  // R8 wraps
    {3'd1, 12'h000, 2'd3, 4'd4, 3'd4, 16'h0000},  // R7 reserved kind
    {3'd0, 12'h000, 2'd0, 4'd0, 3'd1, 16'h0000},  // R4 zero count
    {3'd7, 12'h000, 2'd0, 4'd8, 3'd2, 16'h0000}   // R1 R5 untouched entry
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [SEG_W:0]   seg_count = '0;
  logic             tbl_we = 1'b0;
  logic [SEG_W-1:0] tbl_idx = '0;
  logic [PA_W-1:0]  tbl_base = '0;
  logic [OFF_W:0]   tbl_limit = '0;
  logic             tbl_valid = 1'b0;
  logic [2:0]       tbl_perm = '0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [SEG_W-1:0] req_seg = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic [1:0]       req_acc = '0;
  logic             rsp_valid;
  logic             rsp_ready = 1'b1;
  logic [PA_W-1:0]  rsp_addr;
  logic [2:0]       rsp_fault;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seg_xlate #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_seg_xlate (
    .clk(clk), .rst_n(rst_n), .seg_count(seg_count),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_base(tbl_base),
    .tbl_limit(tbl_limit), .tbl_valid(tbl_valid), .tbl_perm(tbl_perm),
    .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
    .req_off(req_off), .req_acc(req_acc), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog: got %0d cycles exp fewer than 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check_bit(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b exp %0b", tag, got, exp);
    end
  endtask

  task automatic check_rsp(string tag, logic [2:0] ef, logic [PA_W-1:0] ea);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_fault !== ef || rsp_addr !== ea) begin
      fails++;
      $display("FAIL %s: got valid %0b fault %0d addr %h exp valid 1 fault %0d addr %h",
               tag, rsp_valid, rsp_fault, rsp_addr, ef, ea);
    end
  endtask

  task automatic load(input logic [SEG_W-1:0] i, input logic [PA_W-1:0] b,
                      input logic [OFF_W:0] l, input logic v, input logic [2:0] p);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = i; tbl_base = b; tbl_limit = l; tbl_valid = v; tbl_perm = p;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic send(input logic [SEG_W-1:0] s, input logic [OFF_W-1:0] o,
                      input logic [1:0] a, input logic [SEG_W:0] c);
    @(negedge clk);
    req_valid = 1'b1; req_seg = s; req_off = o; req_acc = a; seg_count = c;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_bit("R1 rsp_valid after reset", rsp_valid, 1'b0);
    check_bit("R2 ready when empty", req_ready, 1'b1);
    send(3'd0, 12'h000, 2'd0, 4'd1);
    check_rsp("R1 entry invalid after reset", 3'd2, 16'h0000);

    load(3'd0, 16'h1000, 13'h0100, 1'b1, 3'b101);
    load(3'd1, 16'h2000, 13'h0040, 1'b1, 3'b011);
    load(3'd2, 16'h3000, 13'h0200, 1'b0, 3'b111);
    load(3'd3, 16'hFFF0, 13'h1000, 1'b1, 3'b111);
    load(3'd4, 16'h4000, 13'h0010, 1'b1, 3'b000);

    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][39:37], VEC[i][36:25], VEC[i][24:23], VEC[i][22:19]);
      check_rsp($sformatf("R4-R8 vector %0d", i), VEC[i][18:16], VEC[i][15:0]);
    end

    @(negedge clk);
    check_bit("R2 rsp_valid drops when consumed", rsp_valid, 1'b0);

    // R3 stall: response A held, request B waits
    rsp_ready = 1'b0;
    send(3'd0, 12'h020, 2'd0, 4'd4);
    req_valid = 1'b1; req_seg = 3'd1; req_off = 12'h004; req_acc = 2'd0;
    for (int k = 0; k < 3; k++) begin
      check_bit("R3 not ready while stalled", req_ready, 1'b0);
      check_rsp("R3 held response", 3'd0, 16'h1020);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp("R2 R3 queued request after release", 3'd0, 16'h2004);

    // R10 write and request in one cycle
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 3'd5; tbl_base = 16'h5000; tbl_limit = 13'h0010;
    tbl_valid = 1'b1; tbl_perm = 3'b001;
    req_valid = 1'b1; req_seg = 3'd5; req_off = 12'h004; req_acc = 2'd0; seg_count = 4'd8;
    @(negedge clk);
    tbl_we = 1'b0; req_valid = 1'b0;
    check_rsp("R10 same-cycle write unseen", 3'd2, 16'h0000);
    send(3'd5, 12'h004, 2'd0, 4'd8);
    check_rsp("R10 written entry used", 3'd0, 16'h5004);
    send(3'd5, 12'h004, 2'd1, 4'd8);
    check_rsp("R9 fault has zero address", 3'd4, 16'h0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule